// File: doc/BRIEF.md
# Conversion Result Holding Register with Coherent Byte Reads

This block keeps the most recent 10-bit analog-to-digital conversion result and lets a processor with an 8-bit data path read it as two read-only bytes, a high byte and a low byte. A conversion-complete strobe arrives together with the new result. One control input chooses how the 10 bits are placed across the 16 bits of the two bytes: packed toward the bottom (right) or toward the top (left).

A two-byte read stays coherent. Reading the low byte locks the stored result. Conversions that complete while the lock is held are discarded and are not queued. Reading the high byte releases the lock. When the result is left-placed and 8 bits of precision are enough, software may read only the high byte. That read takes no lock. The result bits are stored exactly as delivered, so a signed value from a differential input keeps its two's complement form.

Top module: `adc_result_lock`

## Requirements
- R1: With left_align_i low, a high-byte read returns {6'b0, result[9:8]} and a low-byte read returns result[7:0].
- R2: With left_align_i high, a high-byte read returns result[9:2] and a low-byte read returns {result[1:0], 6'b0}.
- R3: While unlocked, a cycle with conv_done_i high and rd_lo_i low stores conv_res_i. Reads from the next cycle on return the new value.
- R4: A low-byte read (rd_lo_i high) sets the lock from the next cycle on. A completion in the same cycle as that read, or in any later cycle while the lock is held and no high-byte read is present, leaves the stored result unchanged.
- R5: A high-byte read while locked returns the frozen value and releases the lock in the same cycle. A completion in that same cycle is accepted. A completion that was dropped earlier is not applied later.
- R6: A high-byte read while unlocked returns the current value and does not set the lock.
- R7: After reset, both bytes read 0x00 in either alignment and the lock is clear.
- R8: Writes (wr_lo_i, wr_hi_i with wr_data_i) change neither the stored result nor the lock state.
- R9: The alignment select is applied at read time to the stored value. Changing it reformats the next read and does not change the stored value.
- R10: The stored bits equal conv_res_i bit for bit, with no sign handling (for example, 10'h3FF reads back as 0x03/0xFF when right-placed).
- R11: rd_data_o is 0x00 in any cycle with no read strobe. If rd_lo_i and rd_hi_i are both high, the low-byte read takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | Conversion-complete strobe |
| conv_res_i | input | 10 | Conversion result, valid with the strobe |
| left_align_i | input | 1 | 1 = left-placed, 0 = right-placed |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_hi_i | input | 1 | High-byte read strobe |
| wr_lo_i | input | 1 | Low-byte write strobe (ignored) |
| wr_hi_i | input | 1 | High-byte write strobe (ignored) |
| wr_data_i | input | 8 | Write data (ignored) |
| rd_data_o | output | 8 | Read data, combinational from the strobes |

## Verification
A lock bit stuck low shows up on the first high-byte read after a low-byte read that had a completion in between: the high byte then carries bits of a different conversion than the low byte. A lock bit stuck high shows up as a result that never changes after the first low-byte read. A wrong capture enable, or a dropped completion that gets applied late, shows up on the next read of either byte. Every one of these errors appears at rd_data_o within one to three cycles of the stimulus that exposes it.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  typedef enum logic { ALIGN_RIGHT = 1'b0, ALIGN_LEFT = 1'b1 } align_e;
endpackage

// File: rtl/adc_res_lock_ctrl.sv
module adc_res_lock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_done_i,
  input  logic rd_lo_i,
  input  logic rd_hi_i,
  output logic lock_o,
  output logic accept_o
);
  logic lock_q, lock_d, held;

  // lock stays effective this cycle unless a high read releases it
  assign held     = lock_q & ~rd_hi_i;
  assign accept_o = conv_done_i & ~rd_lo_i & ~held;

  always_comb begin
    lock_d = lock_q;
    if (rd_lo_i)      lock_d = 1'b1;
    else if (rd_hi_i) lock_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_d;
  end

  assign lock_o = lock_q;

  AST_LOCK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> lock_q);                                   // R4
  AST_LOCK_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !rd_lo_i) |=> !lock_q);                    // R5
  AST_HI_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && !rd_lo_i) |=> !lock_q);                    // R6
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] res_i,
  output logic [RES_W-1:0] res_o
);
  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= res_i;
  end

  assign res_o = res_q;

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(res_q));                           // R4
endmodule

// File: rtl/adc_res_format.sv
module adc_res_format
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res_i,
  input  align_e            align_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  localparam int WIDE_W = 2 * BYTE_W;
  localparam int PAD_W  = WIDE_W - RES_W;

  logic [WIDE_W-1:0] wide;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (align_i == ALIGN_LEFT) wide = {res_i, {PAD_W{1'b0}}};
        else                       wide = {{PAD_W{1'b0}}, res_i};
      end
    end else begin : g_full
      always_comb wide = res_i;
      logic unused_align;
      assign unused_align = align_i;
    end
  endgenerate

  assign hi_o = wide[WIDE_W-1:BYTE_W];
  assign lo_o = wide[BYTE_W-1:0];
endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_res_i,
  input  logic              left_align_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int PAD_W = 2 * BYTE_W - RES_W;

  logic             lock, accept;
  logic [RES_W-1:0] res;
  logic [BYTE_W-1:0] hi_b, lo_b;
  align_e           align;

  // register is read-only; write port exists only on the bus
  logic unused_wr;
  assign unused_wr = ^{wr_lo_i, wr_hi_i, wr_data_i};

  assign align = left_align_i ? ALIGN_LEFT : ALIGN_RIGHT;

  adc_res_lock_ctrl u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_done_i(conv_done_i),
    .rd_lo_i    (rd_lo_i),
    .rd_hi_i    (rd_hi_i),
    .lock_o     (lock),
    .accept_o   (accept)
  );

  adc_res_store #(.RES_W(RES_W)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .res_i (conv_res_i),
    .res_o (res)
  );

  adc_res_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .res_i  (res),
    .align_i(align),
    .hi_o   (hi_b),
    .lo_o   (lo_b)
  );

  always_comb begin
    if (rd_lo_i)      rd_data_o = lo_b;
    else if (rd_hi_i) rd_data_o = hi_b;
    else              rd_data_o = '0;
  end

  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !lock && !rd_lo_i) |=> res == $past(conv_res_i));   // R3
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && !rd_hi_i) |=> $stable(res));                             // R4
  AST_RIGHT_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !rd_lo_i && !left_align_i) |->
      rd_data_o[BYTE_W-1:BYTE_W-PAD_W] == '0);                        // R1
  AST_LEFT_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && left_align_i) |-> rd_data_o[PAD_W-1:0] == '0);        // R2
  AST_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_lo_i && !rd_hi_i) |-> rd_data_o == '0);                      // R11
endmodule

// File: tb/adc_result_lock_tb.sv
`timescale 1ns/1ps
module adc_result_lock_tb;
  logic       clk = 0, rst_n = 0;
  logic       conv = 0, la = 0, rlo = 0, rhi = 0, wlo = 0, whi = 0;
  logic [9:0] cres = 0;
  logic [7:0] wd = 0, rdata;
  int total = 0, bad = 0;

  logic [9:0] m_res = 0;
  logic       m_lock = 0;

  always #2 clk = ~clk;

  adc_result_lock u_dut (
    .clk_i(clk), .rst_ni(rst_n), .conv_done_i(conv), .conv_res_i(cres),
    .left_align_i(la), .rd_lo_i(rlo), .rd_hi_i(rhi), .wr_lo_i(wlo),
    .wr_hi_i(whi), .wr_data_i(wd), .rd_data_o(rdata)
  );

  function automatic logic [7:0] fmt(logic [9:0] v, logic left, logic lo, logic hi);
    logic [15:0] w;
    w = left ? {v, 6'b0} : {6'b0, v};
    if (lo)      return w[7:0];
    else if (hi) return w[15:8];
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] exp);
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, rdata, exp);
    end
  endtask

  // drive at negedge, check before edge, advance model on edge
  task automatic cyc(string tag, logic c, logic [9:0] r, logic l, logic lo, logic hi,
                     logic wl = 0, logic wh = 0, logic [7:0] d = 0);
    conv = c; cres = r; la = l; rlo = lo; rhi = hi; wlo = wl; whi = wh; wd = d;
    #1;
    chk(tag, fmt(m_res, l, lo, hi));
    @(posedge clk);
    if (c && !lo && !(m_lock && !hi)) m_res = r;
    if (lo)      m_lock = 1;
    else if (hi) m_lock = 0;
    @(negedge clk);
  endtask

  task automatic expect_lit(string tag, logic l, logic lo, logic hi, logic [7:0] exp);
    conv = 0; la = l; rlo = lo; rhi = hi; wlo = 0; whi = 0;
    #1; chk(tag, exp);
    @(posedge clk);
    if (lo) m_lock = 1; else if (hi) m_lock = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R7 reset value
    expect_lit("R7", 0, 1, 0, 8'h00);
    expect_lit("R7", 1, 0, 1, 8'h00);
    expect_lit("R7", 1, 1, 0, 8'h00);
    expect_lit("R7", 0, 0, 1, 8'h00);
    // R3 / R1 / R10 capture and right placement
    cyc("R3", 1, 10'h3FF, 0, 0, 0);
    expect_lit("R10", 0, 1, 0, 8'hFF);
    expect_lit("R1", 0, 0, 1, 8'h03);
    cyc("R3", 1, 10'h2C5, 0, 0, 0);
    expect_lit("R1", 0, 1, 0, 8'hC5);
    expect_lit("R1", 0, 0, 1, 8'h02);
    // R2 / R9 left placement of same stored value
    expect_lit("R9", 1, 0, 1, 8'hB1);
    expect_lit("R2", 1, 1, 0, 8'h40);
    expect_lit("R2", 1, 0, 1, 8'hB1);
    // R4: lock, completions dropped (including same-cycle as low read)
    cyc("R4", 1, 10'h155, 0, 1, 0);
    cyc("R4", 1, 10'h0AA, 0, 0, 0);
    cyc("R4", 1, 10'h111, 0, 0, 0);
    expect_lit("R4", 0, 0, 1, 8'h02);
    // R5: dropped not queued
    expect_lit("R5", 0, 1, 0, 8'hC5);
    expect_lit("R5", 0, 0, 1, 8'h02);
    // R5: completion on the releasing high read is accepted
    cyc("R5", 0, 0, 0, 1, 0);
    cyc("R5", 1, 10'h1E7, 0, 0, 1);
    expect_lit("R5", 0, 1, 0, 8'hE7);
    expect_lit("R5", 0, 0, 1, 8'h01);
    // R6: high-only read takes no lock
    expect_lit("R6", 1, 0, 1, 8'h79);
    cyc("R6", 1, 10'h204, 1, 0, 0);
    expect_lit("R6", 1, 0, 1, 8'h81);
    // R8: writes ignored, also during lock
    cyc("R8", 0, 0, 0, 0, 0, 1, 1, 8'h5A);
    expect_lit("R8", 0, 1, 0, 8'h04);
    cyc("R8", 0, 0, 0, 0, 0, 1, 1, 8'hA5);
    cyc("R8", 1, 10'h3C3, 0, 0, 0);
    expect_lit("R8", 0, 0, 1, 8'h02);
    // R11: idle bus and simultaneous strobes
    expect_lit("R11", 0, 0, 0, 8'h00);
    cyc("R11", 0, 0, 0, 1, 1);
    cyc("R11", 1, 10'h0F0, 0, 0, 0);
    expect_lit("R11", 0, 0, 1, 8'h02);
    // random traffic against bench model
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] k;
      k = 4'($urandom);
      cyc("R4", k[0], 10'($urandom), k[1], ($urandom % 4) == 0, ($urandom % 4) == 0,
          k[2], k[3], 8'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule